// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a three-wire link to an 8-bit serial analog-to-digital converter. The converter is driven by a chip select and an I/O clock and returns one data line. On a start request the controller lowers chip select and waits out the setup interval. It then issues exactly eight I/O clock pulses, sampling one data bit at the end of each high phase, most significant bit first. It raises chip select on the eighth falling edge, presents the assembled byte together with a one-cycle valid strobe, and then holds off any new access until the conversion wait has run out.

Each access returns the result of the conversion that the access before it started, and the access also starts the next conversion. The byte from the first access after reset was therefore never requested, and it is marked with a flag. A start request that arrives while an access or a conversion wait is in progress is held, and it is served as soon as the wait ends. Any number of requests in that window merge into one access. All intervals are counted in cycles of the host clock and set by parameters.

Top module: `sadc_rd_ctrl`

## Requirements
- R1: During reset and right after it, `cs_n_o` is 1, `sclk_o` is 0 and `valid_o` is 0.
- R2: After `cs_n_o` falls, `sclk_o` first rises exactly SETUP_CYC host cycles later.
- R3: Each access has exactly eight `sclk_o` pulses. Every high phase lasts HALF_CYC cycles, and every low phase between two pulses also lasts HALF_CYC cycles.
- R4: The bit on `miso_i` is sampled in the last cycle of each high phase. The first sample becomes bit 7 of `data_o`, so the byte is assembled MSB first.
- R5: `cs_n_o` rises in the same cycle as the eighth falling edge of `sclk_o`. `valid_o` is 1 for exactly that one cycle, and `data_o` changes only when `valid_o` is 1.
- R6: Once `cs_n_o` has risen, it stays high for at least CONV_CYC cycles, and `sclk_o` stays low while it is high.
- R7: A start request made during an access or a conversion wait is held. Chip select then falls CONV_CYC+1 cycles after it rose. Several such requests lead to a single access.
- R8: `first_o` is 1 with the first valid byte after reset and 0 with every later one.
- R9: `sclk_o` is never 1 while `cs_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host system clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one read access (level sampled per cycle) |
| miso_i | input | 1 | Serial data returned by the converter |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Converter I/O clock, idles low |
| data_o | output | DATA_W | Byte captured by the last access |
| valid_o | output | 1 | One-cycle strobe marking a new `data_o` |
| first_o | output | 1 | The current byte is the stale first result after reset |

## Verification
Two functions can fall in the same cycle: a new start request can arrive in the very cycle the conversion wait expires, while the controller is leaving the wait and returning to idle. The bench provokes this by placing a one-cycle request at every offset from the end of an access to beyond the end of the wait. For each offset it computes the chip-select high time as max(CONV_CYC+1, offset) and checks that exactly one access follows. A second case places two requests inside one wait, and a third places one request inside a running access; neither may produce an extra or a missing access.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_CONV
  } rd_state_e;
endpackage

// File: rtl/sadc_timer.sv
module sadc_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] next_word,
  output logic              last
);
  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sr_q;
  logic [BW-1:0]     idx_q;

  assign next_word = {sr_q[DATA_W-2:0], bit_in};
  assign last      = (idx_q == BW'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (shift_en) begin
      sr_q  <= next_word;
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end

  // R3: after the final shift the bit index must have wrapped to zero
  assert_idx_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && last && !clr) |=> (idx_q == '0));
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CW        = 8,
  parameter int SETUP_CYC = 70,
  parameter int HALF_CYC  = 23,
  parameter int CONV_CYC  = 850
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              miso_i,
  input  logic              tmr_zero,
  input  logic [DATA_W-1:0] shf_word,
  input  logic              shf_last,
  output logic              tmr_load,
  output logic [CW-1:0]     tmr_val,
  output logic              shf_clr,
  output logic              shf_en,
  output logic              shf_bit,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              first_o
);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HALF_LD  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] CONV_LD  = CW'(CONV_CYC - 1);

  rd_state_e         st_q;
  logic              cs_n_q, sclk_q, valid_q, first_q, seen_q, pend_q;
  logic [DATA_W-1:0] data_q;
  logic              go;

  assign go      = start_i || pend_q;
  assign shf_clr = (st_q == ST_IDLE) && go;
  assign shf_en  = (st_q == ST_HIGH) && tmr_zero;
  assign shf_bit = miso_i;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = HALF_LD;
    unique case (st_q)
      ST_IDLE:  begin tmr_load = go;       tmr_val = SETUP_LD; end
      ST_SETUP: begin tmr_load = tmr_zero; tmr_val = HALF_LD;  end
      ST_HIGH:  begin
        tmr_load = tmr_zero;
        tmr_val  = shf_last ? CONV_LD : HALF_LD;
      end
      ST_LOW:   begin tmr_load = tmr_zero; tmr_val = HALF_LD;  end
      ST_CONV:  begin tmr_load = 1'b0;     tmr_val = HALF_LD;  end
      default:  begin tmr_load = 1'b0;     tmr_val = HALF_LD;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      valid_q <= 1'b0;
      first_q <= 1'b0;
      seen_q  <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start_i && st_q != ST_IDLE) pend_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (go) begin
          cs_n_q <= 1'b0;
          pend_q <= 1'b0;
          st_q   <= ST_SETUP;
        end
        ST_SETUP: if (tmr_zero) begin
          sclk_q <= 1'b1;
          st_q   <= ST_HIGH;
        end
        ST_HIGH: if (tmr_zero) begin
          sclk_q <= 1'b0;
          if (shf_last) begin
            cs_n_q  <= 1'b1;
            valid_q <= 1'b1;
            data_q  <= shf_word;
            first_q <= !seen_q;
            seen_q  <= 1'b1;
            st_q    <= ST_CONV;
          end else begin
            st_q <= ST_LOW;
          end
        end
        ST_LOW: if (tmr_zero) begin
          sclk_q <= 1'b1;
          st_q   <= ST_HIGH;
        end
        ST_CONV: if (tmr_zero) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o  = cs_n_q;
  assign sclk_o  = sclk_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign first_o = first_q;

  // R9: the I/O clock stays low whenever chip select is high
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sclk_q);
  // R5: chip select rises together with the last falling edge and the strobe
  assert_end_together_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_q) |-> ($fell(sclk_q) && valid_q));
  // R5: the strobe lasts a single cycle
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  // R5: the output byte holds between strobes
  assert_hold_data_R5: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(data_q));
  // R7: a request inside the conversion wait is remembered
  assert_pending_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CONV && start_i) |=> pend_q);
  // R8: only the first byte after reset carries the flag
  assert_first_once_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(seen_q)) |-> !first_q);
endmodule

// File: rtl/sadc_rd_ctrl.sv
module sadc_rd_ctrl #(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 70,
  parameter int HALF_CYC  = 23,
  parameter int CONV_CYC  = 850
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              miso_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              first_o
);
  localparam int MAX_SH = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int MAX_C  = (MAX_SH > CONV_CYC) ? MAX_SH : CONV_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  logic              tmr_load, tmr_zero;
  logic [CW-1:0]     tmr_val;
  logic              shf_clr, shf_en, shf_bit, shf_last;
  logic [DATA_W-1:0] shf_word;

  sadc_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sadc_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .clr       (shf_clr),
    .shift_en  (shf_en),
    .bit_in    (shf_bit),
    .next_word (shf_word),
    .last      (shf_last)
  );

  sadc_seq #(
    .DATA_W    (DATA_W),
    .CW        (CW),
    .SETUP_CYC (SETUP_CYC),
    .HALF_CYC  (HALF_CYC),
    .CONV_CYC  (CONV_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .miso_i   (miso_i),
    .tmr_zero (tmr_zero),
    .shf_word (shf_word),
    .shf_last (shf_last),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .shf_clr  (shf_clr),
    .shf_en   (shf_en),
    .shf_bit  (shf_bit),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .first_o  (first_o)
  );
endmodule

// File: tb/test_sadc_rd_ctrl.sv
module test_sadc_rd_ctrl;
  localparam int SETUP = 3;
  localparam int HALF  = 2;
  localparam int CONV  = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       miso_i;
  logic       cs_n_o, sclk_o, valid_o, first_o;
  logic [7:0] data_o;

  always #10 clk = ~clk;

  sadc_rd_ctrl #(
    .DATA_W(8), .SETUP_CYC(SETUP), .HALF_CYC(HALF), .CONV_CYC(CONV)
  ) i_sadc_rd_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .miso_i(miso_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .data_o(data_o),
    .valid_o(valid_o), .first_o(first_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Converter model: MSB out on chip-select fall, shift on each falling I/O clock,
  // new conversion value taken on the eighth falling edge.
  logic [7:0] ain      = 8'h00;
  logic [7:0] conv_val = 8'hA5;
  logic [7:0] adc_sr   = 8'h00;
  logic [7:0] loaded   = 8'h00;
  int         nfall    = 8;

  assign miso_i = adc_sr[7];

  always @(negedge cs_n_o) begin
    adc_sr = conv_val;
    loaded = conv_val;
    nfall  = 0;
  end

  always @(negedge sclk_o) begin
    if (nfall < 8) begin
      adc_sr = adc_sr << 1;
      nfall++;
      if (nfall == 8) conv_val = ain;
    end
  end

  // Port monitor, sampled on the falling host clock edge
  logic       p_cs = 1'b1, p_sclk = 1'b0;
  int         run = 0, hi_run = 0, pulses = 0, nacc = 0, nvalid = 0, last_gap = 0;
  logic [7:0] last_data = 8'h00;

  always @(negedge clk) begin
    if (rst) begin
      chk(cs_n_o == 1'b1 && sclk_o == 1'b0 && valid_o == 1'b0, "R1 reset outputs",
          {cs_n_o, sclk_o, valid_o}, 3'b100);
      last_data = data_o;
    end else begin
      if (cs_n_o && sclk_o) chk(1'b0, "R9 clock high while deselected", 1, 0);
      if (!cs_n_o && p_cs) begin
        nacc++;
        if (nacc > 1) chk(hi_run >= CONV, "R6 deselect time", hi_run, CONV);
        last_gap = hi_run;
        pulses   = 0;
        run      = 1;
      end else if (sclk_o != p_sclk) begin
        if (sclk_o) begin
          if (pulses == 0) chk(run == SETUP, "R2 setup cycles", run, SETUP);
          else             chk(run == HALF, "R3 low phase", run, HALF);
          pulses++;
        end else begin
          chk(run == HALF, "R3 high phase", run, HALF);
        end
        run = 1;
      end else begin
        run++;
      end
      if (cs_n_o && !p_cs) begin
        chk(pulses == 8, "R3 pulse count", pulses, 8);
        chk(p_sclk && !sclk_o, "R5 select rises on last fall", {p_sclk, sclk_o}, 2'b10);
        chk(valid_o == 1'b1, "R5 strobe with select rise", valid_o, 1);
      end else if (valid_o) begin
        chk(1'b0, "R5 stray strobe", 1, 0);
      end
      if (valid_o) begin
        chk(data_o == loaded, "R4 captured byte", data_o, loaded);
        chk(first_o == (nvalid == 0), "R8 first flag", first_o, nvalid == 0);
        nvalid++;
      end else begin
        chk(data_o == last_data, "R5 data held", data_o, last_data);
      end
      last_data = data_o;
      hi_run    = cs_n_o ? hi_run + 1 : 0;
    end
    p_cs   = cs_n_o;
    p_sclk = sclk_o;
  end

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!valid_o);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R1 idle after reset", {cs_n_o, sclk_o}, 2'b10);

    // Full sweep of converter values; each read returns the previous value (R4, R8)
    for (int v = 0; v < 256; v++) begin
      ain = v[7:0];
      @(negedge clk);
      pulse_start();
      wait_valid();
    end

    // R7: request at every offset around the end of the conversion wait
    for (int d = 0; d <= CONV + 3; d++) begin
      ain = 8'(d * 37 + 5);
      repeat (d) @(negedge clk);
      pulse_start();
      wait_valid();
      chk(last_gap == ((CONV + 1 > d + 1) ? CONV + 1 : d + 1), "R7 request offset gap",
          last_gap, (CONV + 1 > d + 1) ? CONV + 1 : d + 1);
    end

    // R7: two requests inside one wait give one access
    begin
      int n0;
      @(negedge clk);
      pulse_start();
      repeat (2) @(negedge clk);
      pulse_start();
      n0 = nacc;
      wait_valid();
      repeat (CONV + 20) @(negedge clk);
      chk(nacc == n0 + 1, "R7 merged requests", nacc - n0, 1);
      chk(cs_n_o == 1'b1, "R7 no extra access", cs_n_o, 1);
    end

    // R7: request during a running access is served after the wait
    begin
      int n1;
      pulse_start();
      do @(negedge clk); while (cs_n_o);
      pulse_start();
      wait_valid();
      n1 = nacc;
      wait_valid();
      chk(nacc == n1 + 1, "R7 queued access count", nacc - n1, 1);
      chk(last_gap == CONV + 1, "R7 queued access gap", last_gap, CONV + 1);
      repeat (CONV + 20) @(negedge clk);
      chk(cs_n_o == 1'b1, "R6 idle after queued access", cs_n_o, 1);
    end

    finish_up();
  end
endmodule